// File: doc/BRIEF.md
# Two-Pixel Readout Timing Sequencer

This block generates the control waveforms for reading out one image-sensor channel that carries two pixels per output line. Each pixel read follows the same fixed script. The script selects the pixel with one of two select phases. It then issues a one-tick transmit strobe for the sample converted in the previous pixel read. After that it settles, resets the analog integrator, settles again and integrates. Partway through the integration window it loads the previous A/D result into a FIFO. It then stops integrating, pulses the converter, deselects the pixel, and holds with both phases low before the other pixel may be selected.

Each step lasts its programmed delay plus a fixed overhead, and the result is rounded up to whole ticks of the clock. With the default 40 ns clock one pixel script is 191 cycles long. Pixel A (the first of the pair) and pixel B alternate while `run` is high. When `run` falls, the script in progress runs to its end and the block then parks idle. The next start always begins with pixel A. The frame-sync level is passed through one register stage so that it lines up with the other outputs. The `step_done` and `pix_a_active` outputs let the step widths be measured from outside the block.

Top module: `pxs_readout_seq`

## Requirements
- R1: While reset is high and while the block is idle, `ana_ctl` is 4'b0111, both select phases are 0, and `tx_strobe` and `step_done` are 0.
- R2: When `run` is sampled high at a rising edge while the block is idle, the select step of pixel A appears on the outputs from the next rising edge onward.
- R3: The script steps, in this order, last the following numbers of 40 ns cycles: select 1, transmit 1, transfer settle 16, integrator reset 20, settle 6, integrate 121, FIFO load 1, integrate tail 11, stop settle 2, convert 2, convert clear 2, deselect 1, hold 7. The total is 191.
- R4: `ana_ctl` has bit 3 as FIFO load (active high), bit 2 as convert (active low), bit 1 as integrator reset (active low) and bit 0 as integrate (active low). Its values per step are: reset 0101, integrate and integrate tail 0110, FIFO load 1110, convert 0011, and 0111 for all other steps.
- R5: From the select step through the convert-clear step, pixel A drives `sel_ph_a`=1 and `sel_ph_b`=0, and pixel B drives the reverse. In the deselect and hold steps both phases are 0. The two phases are never both 1.
- R6: Between the last selected cycle of one pixel and the first selected cycle of the next, both phases are low for at least 8 cycles.
- R7: `tx_strobe` is high for exactly one cycle per pixel script: the cycle right after the select step, while the pixel is selected.
- R8: While `run` stays high, the scripts alternate A, B, A, B and so on without idle cycles between them. `pix_a_active` is 1 during pixel A scripts and 0 otherwise.
- R9: When `run` is low at the last cycle of a script, the block goes idle. A script that has started always completes. The next start selects pixel A.
- R10: The integrate-class nibble values (0110, 1110) form one unbroken window of 133 cycles per pixel. It contains exactly one FIFO-load cycle, placed 121 cycles into the window.
- R11: `step_done` is high on the last output cycle of every step, giving 13 pulses per pixel script.
- R12: `frame_sync_o` equals `frame_sync_i` delayed by one clock (0 during reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per period |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Keep reading pixel pairs while high |
| frame_sync_i | input | 1 | Frame-sync level |
| sel_ph_a | output | 1 | Select phase for pixel A |
| sel_ph_b | output | 1 | Select phase for pixel B |
| frame_sync_o | output | 1 | Registered frame-sync level |
| ana_ctl | output | 4 | Analog chain control nibble |
| tx_strobe | output | 1 | Serial transmit pulse for the previous sample |
| step_done | output | 1 | Last cycle of the current step |
| pix_a_active | output | 1 | A pixel A script is running |

## Verification
The bound checker checks on every cycle that the phases never overlap and that both phases stay low for the minimum gap before any select. It also checks that the nibble keeps to its five legal codes, that the FIFO load sits between integrate cycles, that the transmit strobe is one cycle long and falls inside a selected window, and that the frame-sync register follows its input. The exact step widths, the A/B alternation, the 133-cycle integration window, the two-clock start latency and the completion of the script in progress after `run` falls depend on whole scenarios. These are shown only by the bench. Its reference model expands the step table per pixel and compares every output field on every clock.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

  localparam int unsigned NSTEP = 13;

  typedef enum logic [3:0] {
    ST_SEL   = 4'd0,
    ST_XMIT  = 4'd1,
    ST_XFER  = 4'd2,
    ST_IRST  = 4'd3,
    ST_SETL  = 4'd4,
    ST_INTA  = 4'd5,
    ST_FLD   = 4'd6,
    ST_INTB  = 4'd7,
    ST_STOP  = 4'd8,
    ST_CONV  = 4'd9,
    ST_CLR   = 4'd10,
    ST_DESEL = 4'd11,
    ST_HOLD  = 4'd12
  } step_t;

  // ana_ctl bits: [3] fifo load, [2] convert_n, [1] irst_n, [0] integ_n
  localparam logic [3:0] NIB_IDLE  = 4'b0111;
  localparam logic [3:0] NIB_IRST  = 4'b0101;
  localparam logic [3:0] NIB_INTEG = 4'b0110;
  localparam logic [3:0] NIB_FLOAD = 4'b1110;
  localparam logic [3:0] NIB_CONV  = 4'b0011;

  typedef struct packed {
    logic       ph_a;
    logic       ph_b;
    logic [3:0] nib;
    logic       tx;
  } wave_t;

  function automatic int unsigned ticks_of(int unsigned prog_ns,
                                           int unsigned ovh_ns,
                                           int unsigned tick_ns);
    return (prog_ns + ovh_ns + tick_ns - 1) / tick_ns;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pxs_step_rom.sv
module pxs_step_rom
  import pxs_pkg::*;
#(
  parameter int unsigned TICK_NS = 40,
  parameter int unsigned OVH_NS  = 40,
  parameter int unsigned XFER_NS = 600,
  parameter int unsigned IRST_NS = 760,
  parameter int unsigned SETL_NS = 200,
  parameter int unsigned INTA_NS = 4800,
  parameter int unsigned INTB_NS = 400,
  parameter int unsigned STEP_NS = 40,
  parameter int unsigned HOLD_NS = 240,
  parameter int unsigned CNT_W   = 8
) (
  input  step_t             addr,
  output logic [CNT_W-1:0]  load_val
);

  localparam int unsigned T_ONE = ticks_of(0, OVH_NS, TICK_NS);

  // duration table in ticks, one entry per step in script order
  localparam int unsigned DUR [NSTEP] = '{
    T_ONE,
    T_ONE,
    ticks_of(XFER_NS, OVH_NS, TICK_NS),
    ticks_of(IRST_NS, OVH_NS, TICK_NS),
    ticks_of(SETL_NS, OVH_NS, TICK_NS),
    ticks_of(INTA_NS, OVH_NS, TICK_NS),
    T_ONE,
    ticks_of(INTB_NS, OVH_NS, TICK_NS),
    ticks_of(STEP_NS, OVH_NS, TICK_NS),
    ticks_of(STEP_NS, OVH_NS, TICK_NS),
    ticks_of(STEP_NS, OVH_NS, TICK_NS),
    T_ONE,
    ticks_of(HOLD_NS, OVH_NS, TICK_NS)
  };

  logic [CNT_W-1:0] rom_q [NSTEP];

  for (genvar g = 0; g < NSTEP; g++) begin : g_rom
    assign rom_q[g] = CNT_W'(DUR[g] - 1);
  end

  always_comb begin
    if (int'(addr) < NSTEP) load_val = rom_q[addr];
    else                    load_val = '0;
  end

endmodule

// File: rtl/pxs_tick_cnt.sv
module pxs_tick_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                    cnt_q <= '0;
    else if (load)              cnt_q <= load_val;
    else if (dec && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/pxs_wave_enc.sv
module pxs_wave_enc
  import pxs_pkg::*;
(
  input  logic  busy,
  input  step_t step,
  input  logic  pix_a,
  output wave_t wave
);

  logic selected;

  always_comb begin
    selected = busy && (step <= ST_CLR);
    wave.ph_a = selected && pix_a;
    wave.ph_b = selected && !pix_a;
    wave.tx   = busy && (step == ST_XMIT);
    wave.nib  = NIB_IDLE;
    if (busy) begin
      case (step)
        ST_IRST: wave.nib = NIB_IRST;
        ST_INTA: wave.nib = NIB_INTEG;
        ST_FLD:  wave.nib = NIB_FLOAD;
        ST_INTB: wave.nib = NIB_INTEG;
        ST_CONV: wave.nib = NIB_CONV;
        default: wave.nib = NIB_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pxs_readout_seq.sv
module pxs_readout_seq
  import pxs_pkg::*;
#(
  parameter int unsigned TICK_NS = 40,
  parameter int unsigned OVH_NS  = 40,
  parameter int unsigned XFER_NS = 600,
  parameter int unsigned IRST_NS = 760,
  parameter int unsigned SETL_NS = 200,
  parameter int unsigned INTA_NS = 4800,
  parameter int unsigned INTB_NS = 400,
  parameter int unsigned STEP_NS = 40,
  parameter int unsigned HOLD_NS = 240
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       frame_sync_i,
  output logic       sel_ph_a,
  output logic       sel_ph_b,
  output logic       frame_sync_o,
  output logic [3:0] ana_ctl,
  output logic       tx_strobe,
  output logic       step_done,
  output logic       pix_a_active
);

  localparam int unsigned T_MAX = umax(umax(ticks_of(INTA_NS, OVH_NS, TICK_NS),
                                            ticks_of(IRST_NS, OVH_NS, TICK_NS)),
                                       umax(ticks_of(XFER_NS, OVH_NS, TICK_NS),
                                            umax(ticks_of(HOLD_NS, OVH_NS, TICK_NS),
                                                 ticks_of(INTB_NS, OVH_NS, TICK_NS))));
  localparam int unsigned CNT_W = $clog2(T_MAX + 1);

  logic  busy_q, nxt_busy;
  step_t step_q, nxt_step;
  logic  pix_a_q, nxt_pix_a;
  logic  cnt_zero, cnt_load;
  logic [CNT_W-1:0] load_val;
  wave_t wave;

  // next-state selection
  always_comb begin
    nxt_busy  = busy_q;
    nxt_step  = step_q;
    nxt_pix_a = pix_a_q;
    cnt_load  = 1'b0;
    if (!busy_q) begin
      if (run) begin
        nxt_busy  = 1'b1;
        nxt_step  = ST_SEL;
        nxt_pix_a = 1'b1;
        cnt_load  = 1'b1;
      end
    end else if (cnt_zero) begin
      if (step_q == ST_HOLD) begin
        nxt_step = ST_SEL;
        if (run) begin
          nxt_pix_a = !pix_a_q;
          cnt_load  = 1'b1;
        end else begin
          nxt_busy  = 1'b0;
          nxt_pix_a = 1'b0;
        end
      end else begin
        nxt_step = step_t'(4'(step_q) + 4'd1);
        cnt_load = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      step_q  <= ST_SEL;
      pix_a_q <= 1'b0;
    end else begin
      busy_q  <= nxt_busy;
      step_q  <= nxt_step;
      pix_a_q <= nxt_pix_a;
    end
  end

  pxs_step_rom #(
    .TICK_NS(TICK_NS), .OVH_NS(OVH_NS), .XFER_NS(XFER_NS), .IRST_NS(IRST_NS),
    .SETL_NS(SETL_NS), .INTA_NS(INTA_NS), .INTB_NS(INTB_NS), .STEP_NS(STEP_NS),
    .HOLD_NS(HOLD_NS), .CNT_W(CNT_W)
  ) u_rom (
    .addr     (nxt_step),
    .load_val (load_val)
  );

  pxs_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (load_val),
    .dec      (busy_q),
    .zero     (cnt_zero)
  );

  pxs_wave_enc u_enc (
    .busy  (busy_q),
    .step  (step_q),
    .pix_a (pix_a_q),
    .wave  (wave)
  );

  // registered outputs, one clock behind the step state
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_ph_a     <= 1'b0;
      sel_ph_b     <= 1'b0;
      ana_ctl      <= NIB_IDLE;
      tx_strobe    <= 1'b0;
      step_done    <= 1'b0;
      pix_a_active <= 1'b0;
      frame_sync_o <= 1'b0;
    end else begin
      sel_ph_a     <= wave.ph_a;
      sel_ph_b     <= wave.ph_b;
      ana_ctl      <= wave.nib;
      tx_strobe    <= wave.tx;
      step_done    <= busy_q && cnt_zero;
      pix_a_active <= busy_q && pix_a_q;
      frame_sync_o <= frame_sync_i;
    end
  end

endmodule

// File: rtl/pxs_readout_chk.sv
module pxs_readout_chk #(
  parameter int unsigned MIN_GAP = 8
) (
  input logic       clk,
  input logic       rst,
  input logic       sel_ph_a,
  input logic       sel_ph_b,
  input logic [3:0] ana_ctl,
  input logic       tx_strobe,
  input logic       frame_sync_i,
  input logic       frame_sync_o
);

  localparam int unsigned GW = $clog2(MIN_GAP + 1);

  logic          any_sel;
  logic          prev_sel_q;
  logic [GW-1:0] gap_q;

  assign any_sel = sel_ph_a || sel_ph_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_sel_q <= 1'b0;
      gap_q      <= GW'(MIN_GAP);
    end else begin
      prev_sel_q <= any_sel;
      if (any_sel)                 gap_q <= '0;
      else if (gap_q != GW'(MIN_GAP)) gap_q <= gap_q + 1'b1;
    end
  end

  p_no_overlap_r5: assert property (@(posedge clk) disable iff (rst)
    !(sel_ph_a && sel_ph_b));

  p_min_gap_r6: assert property (@(posedge clk) disable iff (rst)
    (any_sel && !prev_sel_q) |-> (gap_q == GW'(MIN_GAP)));

  p_nib_legal_r4: assert property (@(posedge clk) disable iff (rst)
    (ana_ctl == 4'b0111) || (ana_ctl == 4'b0101) || (ana_ctl == 4'b0110) ||
    (ana_ctl == 4'b1110) || (ana_ctl == 4'b0011));

  p_fload_in_window_r10: assert property (@(posedge clk) disable iff (rst)
    (ana_ctl == 4'b1110) |=> (ana_ctl == 4'b0110));

  p_tx_single_r7: assert property (@(posedge clk) disable iff (rst)
    tx_strobe |=> !tx_strobe);

  p_tx_selected_r7: assert property (@(posedge clk) disable iff (rst)
    tx_strobe |-> (any_sel && prev_sel_q));

  p_fsync_delay_r12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (frame_sync_o == $past(frame_sync_i)));

endmodule

bind pxs_readout_seq pxs_readout_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .sel_ph_a     (sel_ph_a),
  .sel_ph_b     (sel_ph_b),
  .ana_ctl      (ana_ctl),
  .tx_strobe    (tx_strobe),
  .frame_sync_i (frame_sync_i),
  .frame_sync_o (frame_sync_o)
);

// File: tb/pxs_readout_seq_tb.sv
module pxs_readout_seq_tb;

  localparam int CLK_PERIOD = 40;
  localparam int NSTEPS     = 13;
  localparam int WDOG       = 50000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic fs_in = 1'b0;
  logic ph_a, ph_b, fs_out, tx, done, a_act;
  logic [3:0] nib;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pxs_readout_seq u_dut (
    .clk(clk), .rst(rst), .run(run), .frame_sync_i(fs_in),
    .sel_ph_a(ph_a), .sel_ph_b(ph_b), .frame_sync_o(fs_out),
    .ana_ctl(nib), .tx_strobe(tx), .step_done(done), .pix_a_active(a_act)
  );

  // step table from the requirements (R3, R4, R5)
  int         tw  [NSTEPS] = '{1, 1, 16, 20, 6, 121, 1, 11, 2, 2, 2, 1, 7};
  logic [3:0] tn  [NSTEPS] = '{4'h7, 4'h7, 4'h7, 4'h5, 4'h7, 4'h6, 4'hE,
                               4'h6, 4'h7, 4'h3, 4'h7, 4'h7, 4'h7};

  // vector: {ph_a, ph_b, nib[3:0], tx, done, a_act}
  localparam logic [8:0] IDLE_V = {2'b00, 4'h7, 3'b000};

  logic [8:0] q[$];
  logic [8:0] m_cur, m_out;
  logic       m_next_a, m_fs;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // reference model: expands a pixel script into per-cycle vectors
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      q.delete();
      m_cur = IDLE_V; m_out = IDLE_V; m_next_a = 1'b1; m_fs = 1'b0;
    end else begin
      m_out = m_cur;
      m_fs  = fs_in;
      if (q.size() == 0) begin
        if (run) begin
          for (int s = 0; s < NSTEPS; s++)
            for (int i = 0; i < tw[s]; i++)
              q.push_back({(s <= 10) && m_next_a, (s <= 10) && !m_next_a, tn[s],
                           s == 1, i == tw[s]-1, m_next_a});
          m_next_a = !m_next_a;
        end else m_next_a = 1'b1;
      end
      if (q.size() > 0) m_cur = q.pop_front();
      else              m_cur = IDLE_V;
    end
    if (cyc >= WDOG) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // scenario monitors
  int widths[$], integ[$], gaps[$];
  logic order[$];
  int seg = 0, icnt = 0, gcnt = 0, ntx = 0, ndone = 0;
  logic prev_sel = 1'b0;

  task automatic clear_mon();
    widths.delete(); integ.delete(); gaps.delete(); order.delete();
    seg = 0; icnt = 0; gcnt = 0; ntx = 0; ndone = 0;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R5 sel_ph_a", int'(ph_a), int'(m_out[8]));
      chk("R5 sel_ph_b", int'(ph_b), int'(m_out[7]));
      chk("R4 ana_ctl", int'(nib), int'(m_out[6:3]));
      chk("R7 tx_strobe", int'(tx), int'(m_out[2]));
      chk("R11 step_done", int'(done), int'(m_out[1]));
      chk("R8 pix_a_active", int'(a_act), int'(m_out[0]));
      chk("R12 frame_sync_o", int'(fs_out), int'(m_fs));
      // monitors
      seg = ((ph_a || ph_b) && !prev_sel) ? 1 : seg + 1;
      if (done) begin widths.push_back(seg); seg = 0; ndone++; end
      if (nib == 4'h6 || nib == 4'hE) icnt++;
      else if (icnt > 0) begin integ.push_back(icnt); icnt = 0; end
      if ((ph_a || ph_b) && !prev_sel) begin
        gaps.push_back(gcnt); order.push_back(ph_a); gcnt = 0;
      end
      if (!(ph_a || ph_b)) gcnt++;
      if (tx) ntx++;
      prev_sel = ph_a || ph_b;
    end
  end

  always @(negedge clk) fs_in <= cyc[5] ^ cyc[2];

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs during reset have settled to idle
    chk("R1 reset ana_ctl", int'(nib), 7);
    chk("R1 reset phases", int'({ph_a, ph_b}), 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 idle ana_ctl", int'(nib), 7);
    chk("R1 idle tx/done", int'({tx, done}), 0);

    // R2: start latency
    clear_mon();
    run = 1'b1;
    @(negedge clk);
    chk("R2 not yet selected", int'(ph_a), 0);
    @(negedge clk);
    chk("R2 pixel A selected", int'(ph_a), 1);
    repeat (191*3 + 48) @(negedge clk);
    run = 1'b0;              // drop in the middle of the 4th (pixel B) script
    repeat (300) @(negedge clk);

    // R3: step widths of first script
    for (int s = 0; s < NSTEPS; s++)
      chk($sformatf("R3 width step %0d", s), (s < widths.size()) ? widths[s] : -1, tw[s]);
    chk("R10 integration window", (integ.size() > 0) ? integ[0] : -1, 133);
    chk("R6 deselect gap", (gaps.size() > 1) ? gaps[1] : -1, 8);
    chk("R8 selects while run", order.size(), 4);
    for (int k = 0; k < 4 && k < order.size(); k++)
      chk("R8 alternation", int'(order[k]), (k % 2 == 0) ? 1 : 0);
    chk("R7 one strobe per pixel", ntx, 4);
    chk("R11 done count", ndone, 4*13);
    chk("R9 idle after finish", int'({ph_a, ph_b, tx}), 0);
    chk("R9 idle nibble", int'(nib), 7);

    // R9: restart begins with pixel A; single-cycle run gives one script
    clear_mon();
    run = 1'b1;
    @(negedge clk);
    run = 1'b0;
    repeat (260) @(negedge clk);
    chk("R9 one script only", order.size(), 1);
    chk("R9 restart pixel A", (order.size() > 0) ? int'(order[0]) : -1, 1);
    chk("R9 full script done", ndone, 13);

    // R9: run dropped right at a script boundary
    clear_mon();
    run = 1'b1;
    repeat (192) @(negedge clk);
    run = 1'b0;
    repeat (400) @(negedge clk);
    chk("R9 boundary scripts", order.size(), 2);
    chk("R6 gap A to B", (gaps.size() > 1) ? gaps[1] : -1, 8);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule